// File: doc/BRIEF.md
# Static-Sample Auto-Mute Detector

This block watches the two channels of a stereo PCM stream. It mutes a channel once that channel has carried a long, unbroken run of static samples. A sample is static when every bit is zero or every bit is one, so a digital silence of 0 and a silence of -1 both count. Each channel has its own run counter and its own mute flag. Silence on one side therefore never touches the other side.

Samples arrive with a valid strobe in the block's clock domain. Only strobed cycles take part in counting. When a channel has seen the configured number of consecutive static samples, its mute flag rises. From that point its registered sample output is forced to zero. The first sample on that channel that is not static drops the mute at once and restarts the count. An enable input turns the whole function off. While it is low, both channels pass their samples through unmuted and no run is accumulated.

Top module: `automute_stereo`

## Requirements
- R1: A sample counts as static only when all SAMPLE_W bits are 0 or all are 1. Any other value, including one that differs from either pattern by a single bit, counts as non-static.
- R2: With the enable high, a channel's mute flag is 1 after the clock edge that accepts the RUN_LEN-th consecutive static strobed sample. It is 0 after every edge before that one.
- R3: The run counter stops at RUN_LEN. A static run of any length keeps the mute flag at 1 and never wraps it back to 0.
- R4: A strobed non-static sample clears that channel's mute flag and its run at the same edge. Muting again then needs a full RUN_LEN new static samples.
- R5: The two channels are counted and muted independently. A sample on one channel never changes the mute flag or run of the other.
- R6: While the enable is low, both mute flags are 0 and both runs are cleared at every edge. Strobed samples then pass to the outputs unaltered.
- R7: Cycles with the valid strobe low change neither the runs, the mute flags nor the sample outputs.
- R8: On each strobed cycle the sample output takes the input sample, or takes 0 if the channel is muted after that edge.
- R9: While reset is asserted, both mute flags and both sample outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new sample pair |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| mute_en | input | 1 | Auto-mute enable; tie high for normal use |
| mute_left | output | 1 | Left channel muted |
| mute_right | output | 1 | Right channel muted |
| out_left | output | SAMPLE_W | Left sample after muting, registered |
| out_right | output | SAMPLE_W | Right sample after muting, registered |

## Verification
The bench builds the block with SAMPLE_W = 8 and RUN_LEN = 4. A mute threshold is then reached within a handful of vectors, and the table can interleave several complete mute and release sequences on both channels. A 3-bit counter with a threshold of 4 would wrap after eight samples if it did not saturate. A run of 200 static samples therefore shows whether the counter saturates or wraps. The narrow width also keeps the near-static values 0xFE, 0x01, 0x80 and 0x7F easy to set against the two static patterns.

// File: rtl/automute_pkg.sv
package automute_pkg;

  // channel index used by the stereo top
  typedef enum logic [0:0] {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int unsigned NUM_CH = 2;

  // width of a counter able to hold 0..limit
  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((1 << w) <= limit) w++;
    return w;
  endfunction

endpackage

// File: rtl/automute_static_det.sv
module automute_static_det #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                is_static
);

  logic all_zero;
  logic all_ones;

  always_comb begin
    all_zero  = ~(|sample);
    all_ones  = &sample;
    is_static = all_zero | all_ones;
  end

endmodule

// File: rtl/automute_run_cnt.sv
module automute_run_cnt #(
  parameter int unsigned RUN_LEN = 8192,
  localparam int unsigned CNT_W  = automute_pkg::cnt_width(RUN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             valid,
  input  logic             is_static,
  output logic             mute_nxt,
  output logic [CNT_W-1:0] run_q
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] run_nxt;
  logic             run_ce;

  always_comb begin
    run_ce  = ~enable | valid;
    run_nxt = run_q;
    if (!enable) begin
      run_nxt = '0;
    end else if (valid) begin
      if (!is_static)          run_nxt = '0;
      else if (run_q != LIMIT) run_nxt = run_q + 1'b1;
    end
    mute_nxt = enable && (run_nxt == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_ce) run_q <= run_nxt;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT); // R3

  AST_RUN_CLEARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> run_q == '0); // R6

endmodule

// File: rtl/automute_chan.sv
module automute_chan #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                mute_q,
  output logic [SAMPLE_W-1:0] out_q
);

  localparam int unsigned CNT_W = automute_pkg::cnt_width(RUN_LEN);

  logic                is_static;
  logic                mute_nxt;
  logic [CNT_W-1:0]    run_q;
  logic                mute_ce;
  logic                out_ce;
  logic [SAMPLE_W-1:0] out_nxt;

  automute_static_det #(.SAMPLE_W(SAMPLE_W)) u_det (
    .sample    (sample),
    .is_static (is_static)
  );

  automute_run_cnt #(.RUN_LEN(RUN_LEN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .valid     (valid),
    .is_static (is_static),
    .mute_nxt  (mute_nxt),
    .run_q     (run_q)
  );

  always_comb begin
    mute_ce = ~enable | valid;
    out_ce  = valid;
    out_nxt = mute_nxt ? '0 : sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mute_q <= 1'b0;
    else if (mute_ce) mute_q <= mute_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_ce) out_q <= out_nxt;
  end

  AST_RISE_ON_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_q) |-> $past(valid && enable && is_static)); // R2

  AST_RELEASE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && enable && !is_static) |=> !mute_q); // R4

  AST_OFF_UNMUTED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !mute_q); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !valid) |=> ($stable(mute_q) && $stable(out_q))); // R7

  AST_MUTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q |-> out_q == '0); // R8

  AST_MUTE_HAS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q |-> run_q != '0); // R2

endmodule

// File: rtl/automute_stereo.sv
module automute_stereo #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                mute_en,
  output logic                mute_left,
  output logic                mute_right,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);

  import automute_pkg::*;

  logic [SAMPLE_W-1:0] smp_in  [NUM_CH];
  logic [SAMPLE_W-1:0] smp_out [NUM_CH];
  logic [NUM_CH-1:0]   mute_vec;

  always_comb begin
    smp_in[CH_LEFT]  = smp_left;
    smp_in[CH_RIGHT] = smp_right;
    mute_left        = mute_vec[CH_LEFT];
    mute_right       = mute_vec[CH_RIGHT];
    out_left         = smp_out[CH_LEFT];
    out_right        = smp_out[CH_RIGHT];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    automute_chan #(
      .SAMPLE_W (SAMPLE_W),
      .RUN_LEN  (RUN_LEN)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (mute_en),
      .valid  (smp_valid),
      .sample (smp_in[c]),
      .mute_q (mute_vec[c]),
      .out_q  (smp_out[c])
    );
  end

  AST_SEPARATE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mute_en && mute_right && (smp_right == '0)
     && (smp_left != '0) && !(&smp_left)) |=> mute_right && !mute_left); // R5

endmodule

// File: tb/sim_automute_stereo.sv
module sim_automute_stereo;

  localparam int unsigned W      = 8;
  localparam int unsigned RL     = 4;
  localparam time         PERIOD = 10ns;

  logic         clk;
  logic         rst_n;
  logic         smp_valid;
  logic [W-1:0] smp_left;
  logic [W-1:0] smp_right;
  logic         mute_en;
  logic         mute_left;
  logic         mute_right;
  logic [W-1:0] out_left;
  logic [W-1:0] out_right;

  int n_chk;
  int n_bad;

  automute_stereo #(.SAMPLE_W(W), .RUN_LEN(RL)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .mute_en    (mute_en),
    .mute_left  (mute_left),
    .mute_right (mute_right),
    .out_left   (out_left),
    .out_right  (out_right)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // entry: valid, en, left, right, exp mute L, exp mute R, exp out L, exp out R
  localparam int NV = 17;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1,1'b1,8'h00,8'hFF, 1'b0,1'b0,8'h00,8'hFF},  // R1 both static kinds
    {1'b1,1'b1,8'hFF,8'h00, 1'b0,1'b0,8'hFF,8'h00},  // R1 mixed 0/-1 run
    {1'b1,1'b1,8'h00,8'h05, 1'b0,1'b0,8'h00,8'h05},  // R4 right run broken
    {1'b1,1'b1,8'h00,8'h00, 1'b1,1'b0,8'h00,8'h00},  // R2 left reaches 4
    {1'b1,1'b1,8'hFF,8'hFF, 1'b1,1'b0,8'h00,8'hFF},  // R8 left zeroed
    {1'b0,1'b1,8'h33,8'h33, 1'b1,1'b0,8'h00,8'hFF},  // R7 no strobe holds
    {1'b1,1'b1,8'h01,8'h00, 1'b0,1'b0,8'h01,8'h00},  // R4 release, R5
    {1'b1,1'b1,8'h00,8'hFF, 1'b0,1'b1,8'h00,8'h00},  // R5 right mutes alone
    {1'b1,1'b1,8'h80,8'h7F, 1'b0,1'b0,8'h80,8'h7F},  // R1 non-static extremes
    {1'b1,1'b1,8'hFE,8'h00, 1'b0,1'b0,8'hFE,8'h00},  // R1 one bit off -1
    {1'b1,1'b0,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00},  // R6 disabled
    {1'b1,1'b1,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00},  // R6 run restarted
    {1'b1,1'b1,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00},
    {1'b1,1'b1,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00},
    {1'b1,1'b1,8'h00,8'h00, 1'b1,1'b1,8'h00,8'h00},  // R2 both mute
    {1'b0,1'b0,8'h55,8'h55, 1'b0,1'b0,8'h00,8'h00},  // R6 disable w/o strobe
    {1'b1,1'b1,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00}   // R6 counts from zero
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic en, input logic [W-1:0] l,
                      input logic [W-1:0] r);
    smp_valid = v;
    mute_en   = en;
    smp_left  = l;
    smp_right = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    smp_valid = 1'b0;
    mute_en = 1'b1;
    smp_left = 8'h12;
    smp_right = 8'h34;
    repeat (3) @(posedge clk);
    #1;
    check("R9 mute_left in reset", 32'(mute_left), 0);
    check("R9 mute_right in reset", 32'(mute_right), 0);
    check("R9 out_left in reset", 32'(out_left), 0);
    check("R9 out_right in reset", 32'(out_right), 0);
    rst_n = 1'b1;
    #1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][35], VEC[i][34], VEC[i][33:26], VEC[i][25:18]);
      check($sformatf("vector %0d mute_left", i),  32'(mute_left),  32'(VEC[i][17]));
      check($sformatf("vector %0d mute_right", i), 32'(mute_right), 32'(VEC[i][16]));
      check($sformatf("vector %0d out_left", i),   32'(out_left),   32'(VEC[i][15:8]));
      check($sformatf("vector %0d out_right", i),  32'(out_right),  32'(VEC[i][7:0]));
    end

    // R3: long static run must keep the mute without wrapping
    begin
      int drops;
      drops = 0;
      for (int i = 0; i < 200; i++) begin
        step(1'b1, 1'b1, (i % 2 == 0) ? 8'h00 : 8'hFF, 8'h00);
        if (i >= 2 && !(mute_left && mute_right)) drops++;
      end
      check("R3 mute drops during long static run", 32'(drops), 0);
    end

    // R4 + R5: single non-static left sample releases only left
    step(1'b1, 1'b1, 8'h40, 8'h00);
    check("R4 left released", 32'(mute_left), 0);
    check("R5 right still muted", 32'(mute_right), 1);
    check("R8 left passes sample", 32'(out_left), 32'h40);
    step(1'b1, 1'b1, 8'h00, 8'h00);
    step(1'b1, 1'b1, 8'h00, 8'h00);
    step(1'b1, 1'b1, 8'h00, 8'h00);
    check("R4 left needs full new run", 32'(mute_left), 0);
    step(1'b1, 1'b1, 8'h00, 8'h00);
    check("R2 left muted again at 4", 32'(mute_left), 1);

    // R7: many idle cycles with non-static data keep the mute
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 8'h5A, 8'hA5);
    check("R7 left mute held idle", 32'(mute_left), 1);
    check("R7 out_right held idle", 32'(out_right), 0);

    // R9: reset during mute clears outputs
    rst_n = 1'b0;
    #1;
    check("R9 async reset clears mute", 32'(mute_left), 0);
    check("R9 async reset clears out", 32'(out_right), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule